// File: doc/BRIEF.md
# Tagged Word Load/Store Unit

This block executes the memory half of load and store instructions for a small local memory of 2048 words of 32 bits (8 KB). Each cycle it receives an operation code, a base register value that already counts in words, a signed byte offset, the store data, the destination register index and the word program counter of the issuing instruction. It drives a simple synchronous single-port memory interface and returns load results as a register file write port.

The byte offset is converted to words by an arithmetic shift right by two, so its two low bits are dropped. The result is added to the low 11 bits of the base, and the sum wraps inside the 2048-word space. A store always writes a whole word. The low half holds the register value. The high half holds a tag: the issuing instruction's word PC, shifted left by five. Software can later read that tag to learn which instruction produced a given word. A load returns the low half of the addressed word.

Operation is governed by a two-state machine. `ST_IDLE` means no load result is pending. `ST_LOAD_RESP` is the cycle in which the memory read data is valid and is written to the register file. The transition `ST_IDLE -> ST_LOAD_RESP` is taken on a load. `ST_LOAD_RESP -> ST_LOAD_RESP` is taken on a back-to-back load. Both states return to `ST_IDLE` on any other operation.

Top module: `tag_lsu`

## Requirements
- R1: While reset is active and in the first cycle after it, the unit drives mem_en low and rf_we low.
- R2: The word address equals (base[10:0] + (offset >>> 2)) modulo 2048, with the 10-bit offset taken as two's complement. The two low offset bits are discarded, and base bits above bit 10 are ignored.
- R3: A store (op 2'b10) drives mem_en=1, mem_we=1, the address and mem_wdata = {pc[10:0], 5'b00000, st_data[15:0]} in the same cycle it is presented. For example, storing 1 from PC 3 writes 32'h00600001.
- R4: A load (op 2'b01) drives mem_en=1, mem_we=0 and the address in the same cycle it is presented.
- R5: In the cycle after a load is presented, rf_we=1, rf_waddr holds that load's destination index, and rf_wdata equals mem_rdata[15:0].
- R6: Loads on consecutive cycles each produce their own register write on the following consecutive cycles, in order.
- R7: Op 2'b00 (none) and op 2'b11 (reserved) drive mem_en=0, change no memory word and cause no register write in the next cycle.
- R8: A store causes no register write in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 2 | Operation: 00 none, 01 load, 10 store, 11 reserved |
| base_i | input | 16 | Base register value in words |
| offset_i | input | 10 | Signed byte offset |
| st_data_i | input | 16 | Store data |
| pc_i | input | 11 | Word PC of the issuing instruction |
| dst_i | input | 2 | Destination register index for loads |
| mem_en_o | output | 1 | Memory access enable |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 11 | Memory word address |
| mem_wdata_o | output | 32 | Memory write word |
| mem_rdata_i | input | 32 | Memory read word, valid the cycle after a read |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | 2 | Register file write index |
| rf_wdata_o | output | 16 | Register file write data |

## Verification
Address generation is tried with positive, negative and unaligned offsets. This separates a proper arithmetic shift from a logical shift and from plain byte addition. The address is also driven past both ends of the space and given a base with high bits set, which exposes missing wrap or missing truncation. Stores are tried with a small PC and with all-ones PC and data, so a misplaced tag or a non-zero pad is caught. Loads are tried singly and back to back against a memory model, which tells a correct one-cycle alignment from a lost or mis-indexed write. The none and reserved codes are applied to show that they touch neither memory nor registers.

// File: rtl/tag_lsu_pkg.sv
package tag_lsu_pkg;
    typedef enum logic [1:0] {
        LSU_NONE  = 2'b00,
        LSU_LOAD  = 2'b01,
        LSU_STORE = 2'b10,
        LSU_RSVD  = 2'b11
    } lsu_op_e;

    typedef enum logic {
        ST_IDLE      = 1'b0,
        ST_LOAD_RESP = 1'b1
    } lsu_state_e;
endpackage

// File: rtl/tag_lsu_agen.sv
module tag_lsu_agen #(
    parameter int BASE_W = 16,
    parameter int OFF_W  = 10,
    parameter int ADDR_W = 11
) (
    input  logic [BASE_W-1:0] base_i,
    input  logic [OFF_W-1:0]  offset_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int WOFF_W = OFF_W - 2;

    logic [ADDR_W-1:0] off_words;

    // Word offset = byte offset >>> 2, sign-extended or truncated to ADDR_W
    generate
        if (ADDR_W > WOFF_W) begin : g_ext
            assign off_words = {{(ADDR_W-WOFF_W){offset_i[OFF_W-1]}}, offset_i[OFF_W-1:2]};
        end else begin : g_trunc
            assign off_words = offset_i[ADDR_W+1:2];
        end
    endgenerate

    assign addr_o = base_i[ADDR_W-1:0] + off_words;
endmodule

// File: rtl/tag_lsu_wpack.sv
module tag_lsu_wpack #(
    parameter int DATA_W = 16,
    parameter int PC_W   = 11,
    parameter int PAD_W  = 5,
    localparam int WORD_W = DATA_W + PC_W + PAD_W
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [PC_W-1:0]   pc_i,
    output logic [WORD_W-1:0] word_o
);
    assign word_o = {pc_i, {PAD_W{1'b0}}, data_i};
endmodule

// File: rtl/tag_lsu_ctrl.sv
module tag_lsu_ctrl
    import tag_lsu_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  lsu_op_e          op_i,
    input  logic [IDX_W-1:0] dst_i,
    output logic             mem_en_o,
    output logic             mem_we_o,
    output logic             rf_we_o,
    output logic [IDX_W-1:0] rf_waddr_o
);
    lsu_state_e       state_q, state_d;
    logic [IDX_W-1:0] dst_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dst_q   <= '0;
        end else begin
            state_q <= state_d;
            if (op_i == LSU_LOAD) dst_q <= dst_i;
        end
    end

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE:      state_d = (op_i == LSU_LOAD) ? ST_LOAD_RESP : ST_IDLE;
            ST_LOAD_RESP: state_d = (op_i == LSU_LOAD) ? ST_LOAD_RESP : ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        mem_en_o   = (op_i == LSU_LOAD) || (op_i == LSU_STORE);
        mem_we_o   = (op_i == LSU_STORE);
        rf_we_o    = 1'b0;
        rf_waddr_o = dst_q;
        unique case (state_q)
            ST_IDLE:      rf_we_o = 1'b0;
            ST_LOAD_RESP: rf_we_o = 1'b1;
            default:      rf_we_o = 1'b0;
        endcase
        if (!rst_n) begin
            mem_en_o = 1'b0;
            mem_we_o = 1'b0;
        end
    end
endmodule

// File: rtl/tag_lsu.sv
module tag_lsu
    import tag_lsu_pkg::*;
#(
    parameter int BASE_W = 16,
    parameter int OFF_W  = 10,
    parameter int ADDR_W = 11,
    parameter int DATA_W = 16,
    parameter int PC_W   = 11,
    parameter int PAD_W  = 5,
    parameter int IDX_W  = 2,
    localparam int WORD_W = DATA_W + PC_W + PAD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        op_i,
    input  logic [BASE_W-1:0] base_i,
    input  logic [OFF_W-1:0]  offset_i,
    input  logic [DATA_W-1:0] st_data_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [IDX_W-1:0]  dst_i,
    output logic              mem_en_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic              rf_we_o,
    output logic [IDX_W-1:0]  rf_waddr_o,
    output logic [DATA_W-1:0] rf_wdata_o
);
    lsu_op_e op;
    assign op = lsu_op_e'(op_i);

    tag_lsu_agen #(.BASE_W(BASE_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) u_agen (
        .base_i   (base_i),
        .offset_i (offset_i),
        .addr_o   (mem_addr_o)
    );

    tag_lsu_wpack #(.DATA_W(DATA_W), .PC_W(PC_W), .PAD_W(PAD_W)) u_wpack (
        .data_i (st_data_i),
        .pc_i   (pc_i),
        .word_o (mem_wdata_o)
    );

    tag_lsu_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_i       (op),
        .dst_i      (dst_i),
        .mem_en_o   (mem_en_o),
        .mem_we_o   (mem_we_o),
        .rf_we_o    (rf_we_o),
        .rf_waddr_o (rf_waddr_o)
    );

    // Read data arrives in the response cycle; take its low half
    assign rf_wdata_o = mem_rdata_i[DATA_W-1:0];
endmodule

// File: rtl/tag_lsu_chk.sv
module tag_lsu_chk #(
    parameter int DATA_W = 16,
    parameter int PC_W   = 11,
    parameter int PAD_W  = 5,
    parameter int IDX_W  = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [1:0]                op_i,
    input logic [IDX_W-1:0]          dst_i,
    input logic                      mem_en_o,
    input logic                      mem_we_o,
    input logic [DATA_W+PC_W+PAD_W-1:0] mem_wdata_o,
    input logic [DATA_W+PC_W+PAD_W-1:0] mem_rdata_i,
    input logic                      rf_we_o,
    input logic [IDX_W-1:0]          rf_waddr_o,
    input logic [DATA_W-1:0]         rf_wdata_o
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !rf_we_o);

    // R3
    store_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (mem_en_o && mem_wdata_o[DATA_W+PAD_W-1:DATA_W] == '0));

    // R5
    load_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'b01) |=> (rf_we_o && rf_waddr_o == $past(dst_i)));

    // R5
    load_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |-> (rf_wdata_o == mem_rdata_i[DATA_W-1:0]));

    // R7
    idle_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'b00 || op_i == 2'b11) |-> !mem_en_o);

    // R8
    no_spurious_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != 2'b01) |=> !rf_we_o);
endmodule

bind tag_lsu tag_lsu_chk #(
    .DATA_W(DATA_W), .PC_W(PC_W), .PAD_W(PAD_W), .IDX_W(IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_i        (op_i),
    .dst_i       (dst_i),
    .mem_en_o    (mem_en_o),
    .mem_we_o    (mem_we_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i),
    .rf_we_o     (rf_we_o),
    .rf_waddr_o  (rf_waddr_o),
    .rf_wdata_o  (rf_wdata_o)
);

// File: tb/tag_lsu_tb.sv
`timescale 1ns/1ps
module tag_lsu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [15:0] base = '0;
    logic [9:0]  offset = '0;
    logic [15:0] st_data = '0;
    logic [10:0] pc = '0;
    logic [1:0]  dst = '0;
    logic        mem_en, mem_we;
    logic [10:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        rf_we;
    logic [1:0]  rf_waddr;
    logic [15:0] rf_wdata;

    int checks = 0;
    int failures = 0;
    logic [31:0] mem [0:2047];

    always #2 clk = ~clk;

    tag_lsu u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op), .base_i(base), .offset_i(offset),
        .st_data_i(st_data), .pc_i(pc), .dst_i(dst),
        .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
        .rf_we_o(rf_we), .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata)
    );

    // Synchronous single-port memory model
    always @(posedge clk) begin
        if (mem_en && mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_en && !mem_we) mem_rdata <= mem[mem_addr];
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] o, input logic [15:0] b, input logic [9:0] f,
                         input logic [15:0] d, input logic [10:0] p, input logic [1:0] r);
        @(negedge clk);
        op = o; base = b; offset = f; st_data = d; pc = p; dst = r;
        #1;
    endtask

    task automatic go_idle();
        @(negedge clk);
        op = 2'b00;
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        op = 2'b01;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(mem_en == 1'b0, "R1", "mem_en in reset", 32'(mem_en), 0);
        chk(rf_we == 1'b0, "R1", "rf_we in reset", 32'(rf_we), 0);
        op = 2'b00;
        rst_n = 1'b1;
        #1;
        chk(rf_we == 1'b0, "R1", "rf_we after reset", 32'(rf_we), 0);
    endtask

    task automatic t_store_example();
        drive(2'b10, 16'h0020, 10'd0, 16'h0001, 11'd3, 2'd0);
        chk(mem_en && mem_we, "R3", "store enables", {30'd0, mem_en, mem_we}, 32'h3);
        chk(mem_addr == 11'h020, "R3", "store addr", 32'(mem_addr), 32'h20);
        chk(mem_wdata == 32'h0060_0001, "R3", "store word", mem_wdata, 32'h0060_0001);
        go_idle();
        chk(mem[11'h020] == 32'h0060_0001, "R3", "stored memory", mem[11'h020], 32'h0060_0001);
        chk(rf_we == 1'b0, "R8", "no rf write after store", 32'(rf_we), 0);
    endtask

    task automatic t_tag_max();
        drive(2'b10, 16'd40, 10'd0, 16'hFFFF, 11'h7FF, 2'd0);
        chk(mem_wdata == 32'hFFE0_FFFF, "R3", "max tag word", mem_wdata, 32'hFFE0_FFFF);
        go_idle();
    endtask

    task automatic addr_case(input logic [15:0] b, input logic [9:0] f, input logic [10:0] exp);
        drive(2'b01, b, f, 16'd0, 11'd0, 2'd0);
        chk(mem_addr == exp, "R2", "effective address", 32'(mem_addr), 32'(exp));
    endtask

    task automatic t_addr();
        addr_case(16'd5, 10'd8, 11'd7);
        addr_case(16'd5, 10'd7, 11'd6);
        addr_case(16'd5, 10'h3FC, 11'd4);     // -4
        addr_case(16'd5, 10'h3FF, 11'd4);     // -1
        addr_case(16'd2047, 10'd4, 11'd0);
        addr_case(16'd0, 10'h3FC, 11'd2047);  // -4
        addr_case(16'hFFFF, 10'd0, 11'd2047);
        addr_case(16'd100, 10'h200, 11'd2020); // -512
        go_idle();
    endtask

    task automatic t_load();
        drive(2'b10, 16'd9, 10'd0, 16'hBEEF, 11'h155, 2'd0);
        go_idle();
        drive(2'b01, 16'd9, 10'd0, 16'd0, 11'd0, 2'd2);
        chk(mem_en && !mem_we, "R4", "load enables", {30'd0, mem_en, mem_we}, 32'h2);
        chk(mem_addr == 11'd9, "R4", "load addr", 32'(mem_addr), 9);
        go_idle();
        chk(rf_we == 1'b1, "R5", "load rf_we", 32'(rf_we), 1);
        chk(rf_waddr == 2'd2, "R5", "load rf_waddr", 32'(rf_waddr), 2);
        chk(rf_wdata == 16'hBEEF, "R5", "load rf_wdata", 32'(rf_wdata), 32'hBEEF);
        go_idle();
        chk(rf_we == 1'b0, "R5", "rf_we drops", 32'(rf_we), 0);
    endtask

    task automatic t_b2b();
        drive(2'b10, 16'd30, 10'd0, 16'h1111, 11'd1, 2'd0);
        drive(2'b10, 16'd31, 10'd0, 16'h2222, 11'd2, 2'd0);
        drive(2'b01, 16'd30, 10'd0, 16'd0, 11'd0, 2'd1);
        drive(2'b01, 16'd30, 10'd4, 16'd0, 11'd0, 2'd3);
        chk(rf_we && rf_waddr == 2'd1, "R6", "first rf write", {29'd0, rf_we, rf_waddr}, 32'h5);
        chk(rf_wdata == 16'h1111, "R6", "first rf data", 32'(rf_wdata), 32'h1111);
        go_idle();
        chk(rf_we && rf_waddr == 2'd3, "R6", "second rf write", {29'd0, rf_we, rf_waddr}, 32'h7);
        chk(rf_wdata == 16'h2222, "R6", "second rf data", 32'(rf_wdata), 32'h2222);
        go_idle();
    endtask

    task automatic t_none();
        for (int k = 0; k < 2; k++) begin
            logic [1:0] code;
            code = (k == 0) ? 2'b00 : 2'b11;
            drive(code, 16'd50, 10'd0, 16'hDEAD, 11'd9, 2'd1);
            chk(mem_en == 1'b0, "R7", "mem_en for idle code", 32'(mem_en), 0);
            go_idle();
            chk(rf_we == 1'b0, "R7", "no rf write for idle code", 32'(rf_we), 0);
            chk(mem[11'd50] == 32'd0, "R7", "memory untouched", mem[11'd50], 0);
        end
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) mem[i] = '0;
        t_reset();
        t_store_example();
        t_tag_max();
        t_addr();
        t_load();
        t_b2b();
        t_none();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=0x1 expected=0x0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule